// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog peripheral that sits on a simple register bus with byte offsets. Software loads two preload values, picks a prescaler range and starts the count. The counter first runs down the first preload and then the second. When the second stage reaches zero, the block raises a reset pulse of fixed length, an optional timeout pin pulse, or both. Software keeps the system alive by reloading ("kicking") the counter before that point.

The preloads and the reload/flag control byte are guarded. A write to one of them takes effect only when it directly follows the two-byte key 0x80, 0x86 at the key offset. Each key covers exactly one guarded write. A one-way lock bit freezes the configuration and the run state until power-on reset. A sticky timeout flag records an expiry that caused a reset. It survives the ordinary reset input, and only the power-on reset input clears it.

Top module: `wdt_lockable`

## Requirements
- R1: With `por` high, all registers, the key state, the prescaler and the pulse counter are cleared. After reset every readable offset reads 0, and `wdt_rst` and `wdt_pin` are low.
- R2: Writing byte 0x80 to offset 0x0C moves the key checker to a half state from any state. Writing 0x86 to offset 0x0C while in the half state arms it. Any other write to 0x0C returns the checker to idle.
- R3: Offsets 0x00 (first preload), 0x04 (second preload) and 0x0D (control byte) are guarded. A write to one of them is applied only when the checker is armed. Any write to a guarded offset, applied or not, leaves the checker idle.
- R4: An applied write to 0x0D with bit 0 set reloads the counter. The counter takes the first preload in stage one, or the second preload in stage two when the first preload is 0. Offset 0x14 reads the counter.
- R5: When running, the counter steps once every 2^DIV_SHORT_LOG2 cycles if configuration bit 2 is 1, and once every 2^DIV_LONG_LOG2 cycles if it is 0. Timing starts at the write that sets the run bit. Expiry comes after P1+P2+2 steps, or after P2+1 steps when P1 is 0.
- R6: On expiry, a pulse of PULSE_LEN cycles begins. `wdt_rst` carries it when configuration bit 4 is set, and `wdt_pin` carries it when bit 5 is set. The counter reloads as in R4. If the block is unlocked, the run bit clears.
- R7: An expiry with configuration bit 4 set raises the timeout flag, which reads as bit 1 of offset 0x0D. An applied write to 0x0D with bit 1 set clears the flag. An unapplied write leaves it unchanged.
- R8: Bit 1 of offset 0x18 is the run bit. Writing it as 0 stops the counter, and the count holds its value.
- R9: Bit 0 of offset 0x18 is the lock. While it is 1, writes to 0x10 and 0x18 are ignored. The `rst` input does not clear the lock, and only `por` does.
- R10: While locked, an expiry leaves the run bit at 1, and the counter keeps counting from the reloaded value.
- R11: `rst` clears the preloads, the counter, the prescaler and the key state. It keeps the configuration (offset 0x10, bits 5..2), offset 0x18 bits 2..0, the timeout flag and any pulse in progress.
- R12: `rst_cold` follows configuration bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| rst | input | 1 | Ordinary reset, synchronous, active high; keeps sticky state |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 6 | Byte offset of the access |
| wr_data | input | 32 | Write data; byte registers use bits 7..0 |
| rd_data | output | 32 | Read data for `addr`, combinational |
| wdt_rst | output | 1 | Reset pulse on expiry |
| wdt_pin | output | 1 | Timeout pin pulse on expiry |
| rst_cold | output | 1 | Reset type select from configuration |

## Verification
A key checker left in the wrong state shows up on the next guarded write. The write either lands when it should not, or is lost, and the next readback of that preload or of the flag exposes it. An error in the stage or step logic moves the rising edge of the pulse away from its computed cycle, so the bench measures expiry latency exactly in steps of the prescaler. Errors in lock and flag stickiness show up at the readback right after a `rst` pulse or after a rejected write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [5:0] OFF_PRE1  = 6'h00;
    localparam logic [5:0] OFF_PRE2  = 6'h04;
    localparam logic [5:0] OFF_KEY   = 6'h0C;
    localparam logic [5:0] OFF_CTRL  = 6'h0D;
    localparam logic [5:0] OFF_CFG   = 6'h10;
    localparam logic [5:0] OFF_COUNT = 6'h14;
    localparam logic [5:0] OFF_LOCK  = 6'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_ARMED} key_state_e;

    // configuration bits 5..2
    typedef struct packed {
        logic pin_en;
        logic rst_en;
        logic cold;
        logic short_rng;
    } cfg_t;

    // lock register bits 2..0
    typedef struct packed {
        logic tcfg;
        logic run;
        logic lock;
    } lockreg_t;

    function automatic key_state_e key_next(key_state_e cur, logic [7:0] d);
        if (d == KEY_FIRST)
            return KEY_HALF;
        else if (cur == KEY_HALF && d == KEY_SECOND)
            return KEY_ARMED;
        else
            return KEY_IDLE;
    endfunction

    function automatic logic is_guarded(logic [5:0] a);
        return (a == OFF_PRE1) || (a == OFF_PRE2) || (a == OFF_CTRL);
    endfunction

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [5:0] addr,
    input  logic [7:0] wr_byte,
    output logic       armed
);
    key_state_e state;

    always_ff @(posedge clk) begin
        if (rst)
            state <= KEY_IDLE;
        else if (wr_en) begin
            if (addr == OFF_KEY)
                state <= key_next(state, wr_byte);
            else if (is_guarded(addr))
                state <= KEY_IDLE;
        end
    end

    assign armed = (state == KEY_ARMED);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int LONG_LOG2  = 15,
    parameter int SHORT_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic short_rng,
    output logic tick
);
    logic [LONG_LOG2-1:0] div;

    always_ff @(posedge clk) begin
        if (rst || !run)
            div <= '0;
        else
            div <= div + 1'b1;
    end

    assign tick = run && (short_rng ? (&div[SHORT_LOG2-1:0]) : (&div));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic [CNT_W-1:0] count,
    output logic             stage2,
    output logic             expire
);
    assign expire = tick && stage2 && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            stage2 <= 1'b0;
        end else if (reload || expire) begin
            if (pre1 != '0) begin
                count  <= pre1;
                stage2 <= 1'b0;
            end else begin
                count  <= pre2;
                stage2 <= 1'b1;
            end
        end else if (tick) begin
            if (count != '0)
                count <= count - 1'b1;
            else begin
                count  <= pre2;
                stage2 <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
    import wdt_pkg::*;
#(
    parameter int CNT_W          = 32,
    parameter int DIV_LONG_LOG2  = 15,
    parameter int DIV_SHORT_LOG2 = 3,
    parameter int PULSE_LEN      = 16
) (
    input  logic        clk,
    input  logic        por,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [5:0]  addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        wdt_rst,
    output logic        wdt_pin,
    output logic        rst_cold
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic             any_rst;
    logic             key_armed;
    logic [CNT_W-1:0] pre1_q, pre2_q, count;
    logic             stage2, expire, tick;
    cfg_t             cfg_q;
    lockreg_t         lk_q;
    logic             lock_q;
    logic             flag_q;
    logic [PW-1:0]    pcnt;
    logic             ctrl_wr, reload;

    assign any_rst = por || rst;
    assign lock_q  = lk_q.lock;
    assign ctrl_wr = wr_en && (addr == OFF_CTRL) && key_armed;
    assign reload  = ctrl_wr && wr_data[0];

    wdt_keyseq u_key (
        .clk(clk), .rst(any_rst), .wr_en(wr_en), .addr(addr),
        .wr_byte(wr_data[7:0]), .armed(key_armed)
    );

    wdt_prescaler #(.LONG_LOG2(DIV_LONG_LOG2), .SHORT_LOG2(DIV_SHORT_LOG2)) u_psc (
        .clk(clk), .rst(any_rst), .run(lk_q.run),
        .short_rng(cfg_q.short_rng), .tick(tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(any_rst), .tick(tick), .reload(reload),
        .pre1(pre1_q), .pre2(pre2_q), .count(count),
        .stage2(stage2), .expire(expire)
    );

    // guarded preloads, cleared by either reset
    always_ff @(posedge clk) begin
        if (any_rst) begin
            pre1_q <= '0;
            pre2_q <= '0;
        end else if (wr_en && key_armed) begin
            if (addr == OFF_PRE1) pre1_q <= wr_data[CNT_W-1:0];
            if (addr == OFF_PRE2) pre2_q <= wr_data[CNT_W-1:0];
        end
    end

    // sticky state, power-on reset only
    always_ff @(posedge clk) begin
        if (por) begin
            cfg_q  <= '0;
            lk_q   <= '0;
            flag_q <= 1'b0;
            pcnt   <= '0;
        end else begin
            if (wr_en && addr == OFF_CFG && !lk_q.lock)
                cfg_q <= cfg_t'(wr_data[5:2]);

            if (wr_en && addr == OFF_LOCK && !lk_q.lock)
                lk_q <= lockreg_t'(wr_data[2:0]);
            else if (expire && !lk_q.lock)
                lk_q.run <= 1'b0;

            if (expire && cfg_q.rst_en)
                flag_q <= 1'b1;
            else if (ctrl_wr && wr_data[1])
                flag_q <= 1'b0;

            if (expire)
                pcnt <= PW'(PULSE_LEN);
            else if (pcnt != '0)
                pcnt <= pcnt - 1'b1;
        end
    end

    assign wdt_rst  = (pcnt != '0) && cfg_q.rst_en;
    assign wdt_pin  = (pcnt != '0) && cfg_q.pin_en;
    assign rst_cold = cfg_q.cold;

    always_comb begin
        case (addr)
            OFF_PRE1:  rd_data = 32'(pre1_q);
            OFF_PRE2:  rd_data = 32'(pre2_q);
            OFF_CTRL:  rd_data = {30'b0, flag_q, 1'b0};
            OFF_CFG:   rd_data = {26'b0, cfg_q, 2'b0};
            OFF_COUNT: rd_data = 32'(count);
            OFF_LOCK:  rd_data = {29'b0, lk_q};
            default:   rd_data = 32'b0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16
) (
    input logic             clk,
    input logic             por,
    input logic             rst,
    input logic             wr_en,
    input logic [5:0]       addr,
    input logic             clr_bit,
    input logic             armed,
    input logic [CNT_W-1:0] pre1,
    input logic             flag,
    input logic             lock,
    input logic [3:0]       cfg,
    input logic             wdt_rst
);
    localparam int RW = $clog2(PULSE_LEN + 2) + 1;
    logic [RW-1:0] run_len;
    logic          por_d;

    always_ff @(posedge clk) begin
        por_d <= por;
        if (por || !wdt_rst)
            run_len <= '0;
        else
            run_len <= run_len + 1'b1;
    end

    // R1
    always_ff @(posedge clk) begin
        if (por_d)
            por_clear_chk: assert (!flag && !lock && !wdt_rst);
    end

    // R3
    unarmed_pre_chk: assert property (@(posedge clk) disable iff (por || rst)
        (wr_en && addr == OFF_PRE1 && !armed) |=> $stable(pre1));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (por)
        (lock && wr_en && addr == OFF_CFG) |=> $stable(cfg));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (por)
        lock |=> lock);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (por)
        (flag && !(wr_en && addr == OFF_CTRL && armed && clr_bit)) |=> flag);

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (por)
        wdt_rst |-> (run_len < RW'(PULSE_LEN)));
endmodule

bind wdt_lockable wdt_checker #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .addr(addr),
    .clr_bit(wr_data[1]), .armed(key_armed), .pre1(pre1_q), .flag(flag_q),
    .lock(lock_q), .cfg(cfg_q), .wdt_rst(wdt_rst)
);

// File: tb/tb_wdt_lockable.sv
module tb_wdt_lockable;
    localparam int PLEN = 16;
    localparam int STEP = 8;

    logic        clk = 0, por = 1, rst = 0, wr_en = 0;
    logic [5:0]  addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        wdt_rst, wdt_pin, rst_cold;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    wdt_lockable #(.CNT_W(32), .DIV_LONG_LOG2(15), .DIV_SHORT_LOG2(3), .PULSE_LEN(PLEN)) dut (
        .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .wdt_rst(wdt_rst), .wdt_pin(wdt_pin), .rst_cold(rst_cold)
    );

    // {first key byte, second key byte, expect applied}
    localparam logic [16:0] KEYTAB [6] = '{
        {8'h80, 8'h86, 1'b1}, {8'h86, 8'h80, 1'b0}, {8'h80, 8'h80, 1'b0},
        {8'h80, 8'h87, 1'b0}, {8'h12, 8'h86, 1'b0}, {8'h80, 8'h86, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic unlock();
        wr(6'h0C, 32'h80);
        wr(6'h0C, 32'h86);
    endtask

    task automatic setup(input logic [31:0] p1, input logic [31:0] p2);
        unlock(); wr(6'h00, p1);
        unlock(); wr(6'h04, p2);
        unlock(); wr(6'h0D, 32'h1);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!(wdt_rst || wdt_pin) && n < 50000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_end();
        while (wdt_rst || wdt_pin) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, c1, c2, expv;
        int n, w;
        repeat (3) @(negedge clk);
        por = 0;

        // R1 reset state
        rd(6'h14, v); chk("R1 count", v, 0);
        rd(6'h18, v); chk("R1 lockreg", v, 0);
        rd(6'h0D, v); chk("R1 flag", v, 0);
        rd(6'h10, v); chk("R1 cfg", v, 0);
        chk("R1 wdt_rst", 32'(wdt_rst), 0);

        // R2 key sequence table
        expv = 0;
        for (int i = 0; i < 6; i++) begin
            wr(6'h0C, 32'(KEYTAB[i][16:9]));
            wr(6'h0C, 32'(KEYTAB[i][8:1]));
            wr(6'h00, 32'h100 + i);
            if (KEYTAB[i][0]) expv = 32'h100 + i;
            rd(6'h00, v); chk("R2 key table", v, expv);
        end

        // R3 key used up, unarmed writes ignored
        wr(6'h00, 32'h55);
        rd(6'h00, v); chk("R3 single use", v, expv);
        wr(6'h04, 32'h7);
        rd(6'h04, v); chk("R3 pre2 guarded", v, 0);

        // stage timing, short range, reset and pin enabled
        setup(2, 3);
        rd(6'h14, v); chk("R4 reload pre1", v, 2);
        wr(6'h10, 32'h34);
        wr(6'h18, 32'h2);
        measure(n); chk("R5 two stage latency", n, STEP * 7);
        chk("R6 pin with reset", 32'(wdt_pin), 1);
        rd(6'h0D, v); chk("R7 flag set", v, 2);
        w = 0;
        while (wdt_rst) begin w++; @(negedge clk); end
        chk("R6 pulse length", w, PLEN);
        rd(6'h18, v); chk("R6 run cleared", v, 0);
        rd(6'h14, v); chk("R6 counter reloaded", v, 2);

        // R11 ordinary reset
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd(6'h0D, v); chk("R11 flag kept", v, 2);
        rd(6'h10, v); chk("R11 cfg kept", v, 32'h34);
        rd(6'h00, v); chk("R11 pre1 cleared", v, 0);

        // R7 clearing
        wr(6'h0D, 32'h2);
        rd(6'h0D, v); chk("R7 unarmed clear ignored", v, 2);
        unlock(); wr(6'h0D, 32'h2);
        rd(6'h0D, v); chk("R7 armed clear", v, 0);

        // first preload zero skips stage one, pin disabled
        setup(0, 4);
        rd(6'h14, v); chk("R4 reload pre2", v, 4);
        wr(6'h10, 32'h14);
        wr(6'h18, 32'h2);
        measure(n); chk("R5 skip latency", n, STEP * 5);
        chk("R6 pin disabled", 32'(wdt_pin), 0);
        wait_end();

        // pin only, reset disabled: no flag
        unlock(); wr(6'h0D, 32'h2);
        setup(0, 1);
        wr(6'h10, 32'h24);
        wr(6'h18, 32'h2);
        measure(n); chk("R6 pin latency", n, STEP * 2);
        chk("R6 no reset pulse", 32'(wdt_rst), 0);
        rd(6'h0D, v); chk("R7 no flag without reset", v, 0);
        wait_end();

        // kick while running, then stop
        setup(50, 0);
        wr(6'h10, 32'h04);
        wr(6'h18, 32'h2);
        repeat (30) @(negedge clk);
        unlock(); wr(6'h0D, 32'h1);
        rd(6'h14, v); chk("R4 kick running", v, 50);
        repeat (30) @(negedge clk);
        wr(6'h18, 32'h0);
        rd(6'h14, c1);
        repeat (40) @(negedge clk);
        rd(6'h14, c2);
        chk("R8 stop holds", c2, c1);
        chk("R8 counted before stop", 32'(c1 < 50), 1);

        // long range
        setup(0, 0);
        wr(6'h10, 32'h10);
        wr(6'h18, 32'h2);
        measure(n); chk("R5 long range", n, 32768);
        wait_end();

        // lock
        setup(0, 2);
        wr(6'h10, 32'h1C);
        chk("R12 cold select", 32'(rst_cold), 1);
        wr(6'h18, 32'h7);
        measure(n); chk("R5 locked latency", n, STEP * 3);
        wait_end();
        measure(n); chk("R10 locked keeps running", n, STEP);
        wait_end();
        rd(6'h18, v); chk("R10 run stays", v, 7);
        wr(6'h18, 32'h0);
        rd(6'h18, v); chk("R9 lockreg frozen", v, 7);
        wr(6'h10, 32'h0);
        rd(6'h10, v); chk("R9 cfg frozen", v, 32'h1C);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd(6'h18, v); chk("R9 lock survives rst", v, 7);
        @(negedge clk); por = 1;
        @(negedge clk); por = 0;
        rd(6'h18, v); chk("R1 por clears lock", v, 0);
        rd(6'h0D, v); chk("R1 por clears flag", v, 0);
        rd(6'h10, v); chk("R1 por clears cfg", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule